// File: doc/BRIEF.md
# Blit Byte Combiner

This unit forms one destination byte of a block-transfer engine from one byte of source A and one byte of source B, and decides whether the byte is to be stored. Source A goes through a right shift of 0 to 7 bits. The bits that the shift empties at the top come from the previous source-A byte, so a run of bytes is shifted as one continuous bit stream. The shifted byte and source B then go through an eight-function logic/arithmetic stage.

A write enable is derived for every element. It depends on whether the unshifted A byte is zero, on two mask flags, and on an optional errata mode. In that mode every element whose A byte was freshly fetched from memory is written. The surrounding engine presents one element per `in_valid` cycle. It pulses `hist_clr` when a transfer starts or a source-A line ends. It receives the result, registered, one cycle later.

Top module: `blit_combine`

## Requirements
- R1: After synchronous reset, `out_valid`, `out_we` and `out_byte` are 0, and the shift history is 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_we` is never high while `out_valid` is low.
- R3: The shift amount is `func_sel[2:0]`. The A operand is the low 8 bits of {history, A} shifted right by that amount, so the vacated top bits come from the history byte.
- R4: The history takes the unshifted A byte only when the element is written. A suppressed element leaves the history unchanged.
- R5: `hist_clr` sets the history to 0. When it is high together with `in_valid`, that element already sees a zero history.
- R6: `func_sel[5:3]` selects the function: 0 AND, 1 NAND, 2 NOR, 3 OR, 4 XOR, 5 XNOR, 6 A+B mod 256, 7 A-B mod 256.
- R7: With `wr_ctl[0]` set, source B is taken as 0.
- R8: `wr_ctl[1]` enables the write when the unshifted A byte is zero, and `wr_ctl[2]` enables it when that byte is nonzero. The zero test ignores the shift and the history.
- R9: When `wr_ctl[1]` and `wr_ctl[2]` are both clear, every element is written.
- R10: With `errata_en` high, an element with `a_fresh` high is written regardless of the masks. `a_fresh` has no effect while `errata_en` is low.
- R11: When a valid element is not written, `out_byte` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Element strobe |
| a_byte | input | 8 | Source A byte |
| b_byte | input | 8 | Source B byte |
| func_sel | input | 6 | [2:0] shift amount, [5:3] function select |
| wr_ctl | input | 3 | [0] zero B, [1] write on A zero, [2] write on A nonzero |
| errata_en | input | 1 | Enables the fresh-fetch forced write |
| a_fresh | input | 1 | Source A byte was fetched from memory for this element |
| hist_clr | input | 1 | Clears the shift history |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_we | output | 1 | Write enable for the result byte |
| out_byte | output | 8 | Result byte |

## Verification
The bench carries the history across elements through suppressed writes. A design that updated the history on every element, rather than only on writes, would corrupt the byte that follows a skipped one. It tests a zero A byte behind a nonzero history, so a zero test taken after the shift would wrongly drop the write. It clears the history in the same cycle as a valid element, which exposes a clear that only takes effect one cycle late. It also covers the empty mask, the errata override with and without `a_fresh`, and the wrap-around of add and subtract. Each of these mistakes shows up as a wrong byte or a wrong write enable.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int BLIT_W  = 8;
    localparam int SHAMT_W = $clog2(BLIT_W);
    localparam int OP_W    = 3;
    localparam int FUNC_W  = SHAMT_W + OP_W;
    localparam int WCTL_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 3'd0,
        OP_NAND = 3'd1,
        OP_NOR  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_XNOR = 3'd5,
        OP_ADD  = 3'd6,
        OP_SUB  = 3'd7
    } blit_op_e;

    typedef struct packed {
        blit_op_e            op;
        logic [SHAMT_W-1:0]  shamt;
    } blit_func_t;

    typedef struct packed {
        logic on_nonzero;
        logic on_zero;
        logic zero_b;
    } blit_wmask_t;

    typedef struct packed {
        logic              we;
        logic [BLIT_W-1:0] data;
    } blit_result_t;

    function automatic logic [BLIT_W-1:0] funnel_right(
        input logic [BLIT_W-1:0]  hi,
        input logic [BLIT_W-1:0]  lo,
        input logic [SHAMT_W-1:0] amt
    );
        logic [2*BLIT_W-1:0] cat;
        cat = {hi, lo} >> amt;
        return cat[BLIT_W-1:0];
    endfunction

    function automatic logic [BLIT_W-1:0] op_eval(
        input blit_op_e          op,
        input logic [BLIT_W-1:0] x,
        input logic [BLIT_W-1:0] y
    );
        logic [BLIT_W-1:0] r;
        unique case (op)
            OP_AND:  r = x & y;
            OP_NAND: r = ~(x & y);
            OP_NOR:  r = ~(x | y);
            OP_OR:   r = x | y;
            OP_XOR:  r = x ^ y;
            OP_XNOR: r = ~(x ^ y);
            OP_ADD:  r = x + y;
            default: r = x - y;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/blit_history.sv
module blit_history
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              upd,
    input  logic [BLIT_W-1:0] a_in,
    output logic [BLIT_W-1:0] prev_eff
);
    logic [BLIT_W-1:0] prev_q;

    assign prev_eff = clr ? '0 : prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else if (upd) begin
            prev_q <= a_in;
        end else if (clr) begin
            prev_q <= '0;
        end
    end

    // R5: a clear without a write leaves an empty history
    p_clear_empties_r5: assert property (@(posedge clk) disable iff (rst)
        (clr && !upd) |=> (prev_q == '0));

    // R4: no write and no clear keeps the history
    p_hold_without_write_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr && !upd) |=> $stable(prev_q));

endmodule

// File: rtl/blit_write_gate.sv
module blit_write_gate
    import blit_pkg::*;
(
    input  logic              valid,
    input  logic [BLIT_W-1:0] a_raw,
    input  blit_wmask_t       mask,
    input  logic              errata_en,
    input  logic              a_fresh,
    output logic              we
);
    logic a_zero;
    logic en_zero;
    logic en_nonzero;
    logic mask_empty;

    always_comb begin
        a_zero     = (a_raw == '0);
        mask_empty = !mask.on_zero && !mask.on_nonzero;
        en_zero    = mask.on_zero || mask_empty;
        en_nonzero = mask.on_nonzero || mask_empty;
        we = valid && ((en_zero && a_zero) ||
                       (en_nonzero && !a_zero) ||
                       (errata_en && a_fresh));
    end

endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
    import blit_pkg::*;
(
    input  logic              we,
    input  logic [BLIT_W-1:0] a_raw,
    input  logic [BLIT_W-1:0] b_raw,
    input  logic [BLIT_W-1:0] prev,
    input  blit_func_t        func,
    input  logic              zero_b,
    output blit_result_t      res
);
    logic [BLIT_W-1:0] a_shifted;
    logic [BLIT_W-1:0] b_eff;

    always_comb begin
        a_shifted = funnel_right(prev, a_raw, func.shamt);
        b_eff     = zero_b ? '0 : b_raw;
        res.we    = we;
        res.data  = we ? op_eval(func.op, a_shifted, b_eff) : '0;
    end

endmodule

// File: rtl/blit_combine.sv
module blit_combine
    import blit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BLIT_W-1:0] a_byte,
    input  logic [BLIT_W-1:0] b_byte,
    input  logic [FUNC_W-1:0] func_sel,
    input  logic [WCTL_W-1:0] wr_ctl,
    input  logic              errata_en,
    input  logic              a_fresh,
    input  logic              hist_clr,
    output logic              out_valid,
    output logic              out_we,
    output logic [BLIT_W-1:0] out_byte
);
    blit_func_t   func;
    blit_wmask_t  mask;
    logic         we_c;
    logic [BLIT_W-1:0] prev_c;
    blit_result_t res_c;

    assign func = blit_func_t'(func_sel);
    assign mask = blit_wmask_t'(wr_ctl);

    blit_write_gate u_gate (
        .valid     (in_valid),
        .a_raw     (a_byte),
        .mask      (mask),
        .errata_en (errata_en),
        .a_fresh   (a_fresh),
        .we        (we_c)
    );

    blit_history u_hist (
        .clk      (clk),
        .rst      (rst),
        .clr      (hist_clr),
        .upd      (we_c),
        .a_in     (a_byte),
        .prev_eff (prev_c)
    );

    blit_datapath u_dp (
        .we     (we_c),
        .a_raw  (a_byte),
        .b_raw  (b_byte),
        .prev   (prev_c),
        .func   (func),
        .zero_b (mask.zero_b),
        .res    (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_we    <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= in_valid;
            out_we    <= res_c.we;
            out_byte  <= res_c.data;
        end
    end

    // R2: one-cycle latency from strobe to result
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2: no write enable without a result strobe
    p_we_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_we);

    // R9: an empty mask writes every element
    p_empty_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wr_ctl[2:1] == 2'b00) |=> out_we);

    // R10: the errata mode forces the write of a fresh A byte
    p_errata_force_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && errata_en && a_fresh) |=> out_we);

    // R8: zero-only mask drops a nonzero A byte
    p_zero_only_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wr_ctl[2:1] == 2'b01 && a_byte != '0 &&
         !(errata_en && a_fresh)) |=> !out_we);

    // R11: a suppressed element carries a zero byte
    p_skip_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_we) |-> (out_byte == '0));

endmodule

// File: tb/blit_combine_tb.sv
module blit_combine_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] a_byte, b_byte;
    logic [5:0] func_sel;
    logic [2:0] wr_ctl;
    logic       errata_en, a_fresh, hist_clr;
    logic       out_valid, out_we;
    logic [7:0] out_byte;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] m_prev;

    always #5 clk = ~clk;

    blit_combine u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .a_byte(a_byte),
        .b_byte(b_byte), .func_sel(func_sel), .wr_ctl(wr_ctl),
        .errata_en(errata_en), .a_fresh(a_fresh), .hist_clr(hist_clr),
        .out_valid(out_valid), .out_we(out_we), .out_byte(out_byte)
    );

    function automatic logic [7:0] m_op(input logic [2:0] op,
                                        input logic [7:0] x, input logic [7:0] y);
        case (op)
            3'd0: return x & y;
            3'd1: return ~(x & y);
            3'd2: return ~(x | y);
            3'd3: return x | y;
            3'd4: return x ^ y;
            3'd5: return ~(x ^ y);
            3'd6: return 8'(x + y);
            default: return 8'(x - y);
        endcase
    endfunction

    function automatic logic m_we(input logic [7:0] a, input logic [2:0] w,
                                  input logic e, input logic f);
        logic z, nz;
        z  = w[1] || (w[2:1] == 2'b00);
        nz = w[2] || (w[2:1] == 2'b00);
        return (z && a == 8'h00) || (nz && a != 8'h00) || (e && f);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input logic v, input logic [7:0] a,
                        input logic [7:0] b, input logic [5:0] f,
                        input logic [2:0] w, input logic e, input logic fr,
                        input logic c);
        logic [7:0] p, sh, bb, eb;
        logic       ew;
        @(negedge clk);
        in_valid = v; a_byte = a; b_byte = b; func_sel = f; wr_ctl = w;
        errata_en = e; a_fresh = fr; hist_clr = c;
        p  = c ? 8'h00 : m_prev;
        ew = v && m_we(a, w, e, fr);
        sh = 8'(({p, a}) >> f[2:0]);
        bb = w[0] ? 8'h00 : b;
        eb = ew ? m_op(f[5:3], sh, bb) : 8'h00;
        if (ew) m_prev = a;
        else if (c) m_prev = 8'h00;
        @(posedge clk);
        #2;
        chk(req, "out_valid", 32'(out_valid), 32'(v));
        chk(req, "out_we",    32'(out_we),    32'(ew));
        chk(req, "out_byte",  32'(out_byte),  32'(eb));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_prev = 8'h00;
        rst = 1'b1; in_valid = 0; a_byte = 0; b_byte = 0; func_sel = 0;
        wr_ctl = 0; errata_en = 0; a_fresh = 0; hist_clr = 0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "out_valid", 32'(out_valid), 0);
        chk("R1", "out_we",    32'(out_we),    0);
        chk("R1", "out_byte",  32'(out_byte),  0);
        @(negedge clk); rst = 1'b0;

        // R1: history empty after reset: F0 >> 4 with OR, B zeroed
        step("R1", 1, 8'hF0, 8'h77, {3'd3, 3'd4}, 3'b001, 0, 0, 0);
        chk("R1", "direct 0F", 32'(out_byte), 32'h0F);
        // R2: idle cycle
        step("R2", 0, 8'h11, 8'h22, 6'h00, 3'b000, 0, 0, 0);
        // R3: carry from history AB into CD >> 4 gives BC
        step("R3", 1, 8'hAB, 8'h00, {3'd3, 3'd0}, 3'b001, 0, 0, 0);
        step("R3", 1, 8'hCD, 8'h00, {3'd3, 3'd4}, 3'b001, 0, 0, 0);
        chk("R3", "direct BC", 32'(out_byte), 32'hBC);
        // R4: skipped element leaves history CD
        step("R4", 1, 8'h55, 8'h00, {3'd3, 3'd4}, 3'b011, 0, 0, 0);
        step("R4", 1, 8'h12, 8'h00, {3'd3, 3'd4}, 3'b001, 0, 0, 0);
        chk("R4", "direct D1", 32'(out_byte), 32'hD1);
        // R5: clear alone, then clear with a valid element
        step("R5", 0, 8'h00, 8'h00, 6'h00, 3'b000, 0, 0, 1);
        step("R5", 1, 8'h80, 8'h00, {3'd3, 3'd1}, 3'b001, 0, 0, 0);
        chk("R5", "direct 40", 32'(out_byte), 32'h40);
        step("R5", 1, 8'h02, 8'h00, {3'd3, 3'd1}, 3'b001, 0, 0, 1);
        chk("R5", "direct 01", 32'(out_byte), 32'h01);
        // R6: every function on fixed operands, shift 0
        for (int op = 0; op < 8; op++)
            step("R6", 1, 8'h3C, 8'hA5, {3'(op), 3'd0}, 3'b000, 0, 0, 1);
        step("R6", 1, 8'h3C, 8'hA5, {3'd6, 3'd0}, 3'b000, 0, 0, 1);
        chk("R6", "add wrap E1", 32'(out_byte), 32'hE1);
        step("R6", 1, 8'h3C, 8'hA5, {3'd7, 3'd0}, 3'b000, 0, 0, 1);
        chk("R6", "sub wrap 97", 32'(out_byte), 32'h97);
        // R7: B forced to zero under add
        step("R7", 1, 8'h10, 8'h22, {3'd6, 3'd0}, 3'b001, 0, 0, 1);
        chk("R7", "direct 10", 32'(out_byte), 32'h10);
        // R8: zero test on unshifted A behind a full history
        step("R8", 1, 8'hFF, 8'h00, {3'd3, 3'd0}, 3'b000, 0, 0, 1);
        step("R8", 1, 8'h00, 8'h00, {3'd3, 3'd4}, 3'b010, 0, 0, 0);
        chk("R8", "direct we", 32'(out_we), 1);
        chk("R8", "direct F0", 32'(out_byte), 32'hF0);
        step("R8", 1, 8'h00, 8'h09, {3'd3, 3'd0}, 3'b100, 0, 0, 0);
        step("R8", 1, 8'h07, 8'h09, {3'd3, 3'd0}, 3'b100, 0, 0, 0);
        // R9: empty mask writes zero and nonzero A
        step("R9", 1, 8'h00, 8'h5A, {3'd4, 3'd0}, 3'b000, 0, 0, 1);
        step("R9", 1, 8'h81, 8'h5A, {3'd4, 3'd0}, 3'b000, 0, 0, 1);
        // R10: errata override and its absence
        step("R10", 1, 8'h00, 8'h0F, {3'd3, 3'd0}, 3'b100, 1, 1, 1);
        chk("R10", "direct we", 32'(out_we), 1);
        step("R10", 1, 8'h00, 8'h0F, {3'd3, 3'd0}, 3'b100, 1, 0, 1);
        step("R10", 1, 8'h00, 8'h0F, {3'd3, 3'd0}, 3'b100, 0, 1, 1);
        // R11: suppressed element with all-ones function gives 0
        step("R11", 1, 8'h44, 8'h00, {3'd1, 3'd0}, 3'b010, 0, 0, 0);
        chk("R11", "direct 00", 32'(out_byte), 0);

        // Random mix, with A biased toward zero
        for (int i = 0; i < 600; i++) begin
            logic [7:0] ra;
            ra = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            step("R3 R6 R8", ($urandom % 8) != 0, ra, 8'($urandom),
                 6'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 10) == 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule